// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the SPI slave pins and the serial protocol engine and implements the hold function. It samples chip select, the serial clock and the active-low hold input into the system clock domain. It then decides when the engine is frozen. While frozen, the qualified serial-clock edge strobes to the engine are suppressed, so the engine's shift register and bit counter keep their values. When the freeze ends, the frame continues from the exact bit where it stopped.

Entering and leaving the pause depends on the level of the serial clock. A hold request made while the clock is low takes effect at once. A request made while the clock is high waits for the next clock fall, and that fall is absorbed by the pause. Release is accepted only while hold is high and the clock is low. The serial-output enable drops as soon as hold is seen low, whatever the clock is doing. Chip select is still honoured during a pause: deselecting clears the pause and flags the frame as abandoned.

Top module: `spi_hold_pause`

## Requirements
- R1: After reset, with chip select high (deselected), paused_o, so_oe_o, sck_rise_o, sck_fall_o and frame_abort_o are all 0.
- R2: While selected and running, hold low seen together with a low serial clock sets paused_o within SYNC_STAGES+1 system clocks.
- R3: Hold low seen while the serial clock is high leaves paused_o at 0 until the clock falls. The pause then starts on that fall, and that fall gives no sck_fall_o strobe.
- R4: A paused block leaves the pause only when hold is high and the serial clock is low at the same time. A hold rise while the clock is high keeps paused_o at 1 until the clock falls.
- R5: so_oe_o is 0 whenever synchronised hold is low, chip select is high or paused_o is 1, and 1 otherwise.
- R6: While paused_o is 1, no sck_rise_o or sck_fall_o strobes are produced for any serial-clock activity. After release, counting resumes with no lost or extra strobe.
- R7: Chip select going high during a pause gives a one-cycle frame_abort_o pulse, and paused_o is 0 in the following cycle.
- R8: While chip select is high, paused_o stays 0 and no edge strobes are produced, whatever hold and the serial clock do.
- R9: While selected and not paused, each serial-clock rise gives exactly one sck_rise_o strobe and each fall exactly one sck_fall_o strobe. si_o follows si_i after SYNC_STAGES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select from pin, active low |
| sck_i | input | 1 | Serial clock from pin |
| hold_ni | input | 1 | Hold request from pin, active low |
| si_i | input | 1 | Serial data in from pin |
| si_o | output | 1 | Synchronised serial data for the engine |
| sck_rise_o | output | 1 | Qualified serial-clock rise strobe |
| sck_fall_o | output | 1 | Qualified serial-clock fall strobe |
| paused_o | output | 1 | Engine freeze |
| so_oe_o | output | 1 | Serial-output enable (0 means high impedance) |
| frame_abort_o | output | 1 | One-cycle pulse when a paused frame is deselected |

## Verification
The hardest case to reach is the deferred transition: hold changes while the serial clock is high, and the following clock fall must both start or end the pause and be absorbed. The stimulus sweeps every pairing of clock level at hold fall with clock level at hold rise. It toggles the serial clock during each pause and keeps running counts of expected strobes. A lost or extra edge at either boundary then shows up as a count mismatch.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic {PS_RUN = 1'b0, PS_PAUSE = 1'b1} pause_state_e;
  localparam int unsigned PIN_W = 4;
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_HOLD = 1;
  localparam int unsigned PIN_SCK  = 2;
  localparam int unsigned PIN_SI   = 3;
  // reset values: deselected, hold released, clock low, data low
  localparam logic [PIN_W-1:0] PIN_RST = 4'b0011;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hp_edge.sv
module hp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/hp_pause_fsm.sv
module hp_pause_fsm
  import hp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic hold_s_i,
  input  logic sck_s_i,
  output logic paused_o,
  output logic enter_o,
  output logic abort_o
);
  pause_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    enter_o = 1'b0;
    abort_o = 1'b0;
    unique case (st_q)
      PS_RUN: begin
        // low clock level gates entry; a request seen while high waits for the fall
        if (!cs_s_i && !hold_s_i && !sck_s_i) begin
          st_d    = PS_PAUSE;
          enter_o = 1'b1;
        end
      end
      PS_PAUSE: begin
        if (cs_s_i) begin
          st_d    = PS_RUN;
          abort_o = 1'b1;
        end else if (hold_s_i && !sck_s_i) begin
          st_d = PS_RUN;
        end
      end
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PS_RUN;
    else         st_q <= st_d;
  end

  assign paused_o = (st_q == PS_PAUSE);
endmodule

// File: rtl/spi_hold_pause.sv
module spi_hold_pause
  import hp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic si_i,
  output logic si_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic paused_o,
  output logic so_oe_o,
  output logic frame_abort_o
);
  logic [PIN_W-1:0] pin_raw, pin_s;
  logic cs_s, hold_s, sck_s;
  logic rise, fall, enter, run_ok;

  assign pin_raw[PIN_CS]   = cs_ni;
  assign pin_raw[PIN_HOLD] = hold_ni;
  assign pin_raw[PIN_SCK]  = sck_i;
  assign pin_raw[PIN_SI]   = si_i;

  for (genvar g = 0; g < PIN_W; g++) begin : g_sync
    hp_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST[g])
    ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_raw[g]),
      .q_o    (pin_s[g])
    );
  end

  assign cs_s   = pin_s[PIN_CS];
  assign hold_s = pin_s[PIN_HOLD];
  assign sck_s  = pin_s[PIN_SCK];
  assign si_o   = pin_s[PIN_SI];

  hp_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sck_s),
    .rise_o (rise),
    .fall_o (fall)
  );

  hp_pause_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_i   (cs_s),
    .hold_s_i (hold_s),
    .sck_s_i  (sck_s),
    .paused_o (paused_o),
    .enter_o  (enter),
    .abort_o  (frame_abort_o)
  );

  // the fall that starts a deferred pause is absorbed
  assign run_ok     = ~cs_s & ~paused_o & ~enter;
  assign sck_rise_o = rise & run_ok;
  assign sck_fall_o = fall & run_ok;
  assign so_oe_o    = ~cs_s & hold_s & ~paused_o;
endmodule

// File: rtl/spi_hold_pause_chk.sv
module spi_hold_pause_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic hold_s,
  input logic sck_s,
  input logic paused_o,
  input logic so_oe_o,
  input logic sck_rise_o,
  input logic sck_fall_o,
  input logic frame_abort_o
);
  assert_enter_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !hold_s && !sck_s) |=> paused_o);

  assert_enter_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_o) |-> $past(!sck_s && !hold_s));

  assert_stay_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && sck_s && !cs_s) |=> paused_o);

  assert_oe_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_s || paused_o || cs_s) |-> !so_oe_o);

  assert_no_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> !(sck_rise_o || sck_fall_o));

  assert_abort_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_abort_o |=> !paused_o);

  assert_desel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !paused_o);

  assert_one_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sck_rise_o, sck_fall_o}));
endmodule

bind spi_hold_pause spi_hold_pause_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_s          (cs_s),
  .hold_s        (hold_s),
  .sck_s         (sck_s),
  .paused_o      (paused_o),
  .so_oe_o       (so_oe_o),
  .sck_rise_o    (sck_rise_o),
  .sck_fall_o    (sck_fall_o),
  .frame_abort_o (frame_abort_o)
);

// File: tb/spi_hold_pause_tb.sv
module spi_hold_pause_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
  logic si_o, rise_o, fall_o, paused_o, oe_o, abort_o;
  int checks = 0, fails = 0;
  int n_rise = 0, n_fall = 0, n_abort = 0;
  int er = 0, ef = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_pause #(.SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .hold_ni(hold_n),
    .si_i(si), .si_o(si_o), .sck_rise_o(rise_o), .sck_fall_o(fall_o),
    .paused_o(paused_o), .so_oe_o(oe_o), .frame_abort_o(abort_o)
  );

  always @(negedge clk) begin
    if (rise_o)  n_rise++;
    if (fall_o)  n_fall++;
    if (abort_o) n_abort++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      sck = 1'b1; settle();
      sck = 1'b0; settle();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R1 paused", paused_o, 0);
    chk("R1 oe", oe_o, 0);
    chk("R1 strobes", n_rise + n_fall + n_abort, 0);

    // deselected: hold and clock activity do nothing
    hold_n = 1'b0; pulses(2); settle();
    chk("R8 paused", paused_o, 0);
    chk("R8 strobes", n_rise + n_fall, 0);
    hold_n = 1'b1; settle();

    // data path
    cs_n = 1'b0; si = 1'b1; settle();
    chk("R9 si", si_o, 1);
    si = 1'b0; settle();
    chk("R9 si low", si_o, 0);
    chk("R5 oe running", oe_o, 1);

    // sweep clock level at hold fall x clock level at hold rise
    for (int lv_in = 0; lv_in < 2; lv_in++) begin
      for (int lv_out = 0; lv_out < 2; lv_out++) begin
        cs_n = 1'b0; sck = 1'b0; hold_n = 1'b1; settle();
        pulses(2); er += 2; ef += 2;
        chk("R9 rise", n_rise, er);
        chk("R9 fall", n_fall, ef);
        sck = logic'(lv_in); settle();
        if (lv_in == 1) er++;
        hold_n = 1'b0; settle();
        chk("R5 oe on hold", oe_o, 0);
        if (lv_in == 0) chk("R2 paused", paused_o, 1);
        else            chk("R3 deferred", paused_o, 0);
        if (lv_in == 1) begin
          sck = 1'b0; settle();
          chk("R3 paused on fall", paused_o, 1);
          chk("R3 fall absorbed", n_fall, ef);
        end
        pulses(3);
        chk("R6 rise frozen", n_rise, er);
        chk("R6 fall frozen", n_fall, ef);
        sck = logic'(lv_out); settle();
        hold_n = 1'b1; settle();
        chk("R4 paused after rise", paused_o, lv_out);
        chk("R5 oe after rise", oe_o, 1 - lv_out);
        if (lv_out == 1) begin
          sck = 1'b0; settle();
          chk("R4 released on fall", paused_o, 0);
          chk("R4 fall absorbed", n_fall, ef);
        end
        pulses(1); er++; ef++;
        chk("R6 resume rise", n_rise, er);
        chk("R6 resume fall", n_fall, ef);
        cs_n = 1'b1; settle();
      end
    end

    // deselect during pause
    cs_n = 1'b0; hold_n = 1'b0; settle();
    chk("R2 paused pre-abort", paused_o, 1);
    cs_n = 1'b1; settle();
    chk("R7 abort pulse", n_abort, 1);
    chk("R7 cleared", paused_o, 0);
    hold_n = 1'b1; cs_n = 1'b0; settle();
    chk("R5 oe after abort", oe_o, 1);
    chk("R7 running", paused_o, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule